// File: doc/BRIEF.md
# Frame Transmit Retry Controller

This block holds a single outgoing frame and runs its transmission attempts through a line transmitter that handles the bit-level work. Software loads the frame bytes, the total byte count (header byte included) and a retry limit through a small register port, then sets the start bit. The controller raises an attempt request, and the line transmitter fetches bytes through a read port. At the end of each attempt the transmitter reports one outcome: acknowledged, not acknowledged, low-drive error or arbitration lost.

Not-acknowledged and low-drive outcomes are counted in two counters that share one register. After such a failure the controller waits a fixed gap and tries again, as long as retries remain. If the limit is used up it stops and flags a retry timeout. Arbitration loss ends the transfer at once, with no retry. An acknowledged attempt ends it as a success. Each of the three endings sets one write-one-to-clear status bit, and that bit drives its own interrupt line.

Register offsets with the default depth of 16: frame data at 0x00..0x0F, length at 0x10, retry at 0x11, control at 0x12, counters at 0x13, status at 0x14.

Top module: `frame_tx_retry`

## Requirements
- R1: After reset, tx_req and all three interrupt lines are 0, and the control, counter and status registers read 0.
- R2: Writing a value with bit 0 set to control (0x12) while idle starts a transfer. tx_req is 1 from the next cycle, and control bit 0 reads 1 while the transfer is active.
- R3: An outcome of acknowledged (tx_result 2'b00) ends the transfer. Control bit 0 reads 0, tx_req drops, and only status bit 0 (ready, irq_ready) is set.
- R4: Each not-acknowledged outcome (2'b01) adds one to the count in counter bits [3:0]. Each low-drive outcome (2'b10) adds one to the count in bits [7:4].
- R5: After a failed attempt with retries left, tx_req is low for exactly GAP cycles and then rises for the next attempt.
- R6: The retry limit L is bits [6:4] of retry (0x11), taken when the transfer starts. At most L+1 attempts are made. A failure on attempt L+1 ends the transfer and sets only status bit 2 (irq_retry_timeout).
- R7: An arbitration-lost outcome (2'b11) ends the transfer at once, with no further attempt. It sets only status bit 1 (irq_arb_lost) and leaves both counters unchanged.
- R8: Writing status (0x14) clears each bit written as 1. Bits written as 0 keep their value.
- R9: Both counters read 0 once a new transfer has started.
- R10: A write to control while a transfer is active has no effect. The attempt sequence continues and the counters are not cleared.
- R11: Frame bytes written at 0x00..0x0F read back through the register port. The byte at tx_byte_idx appears on tx_byte one cycle later. Length (0x10) drives tx_len.
- R12: reg_rdata shows the register selected by reg_addr one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after address |
| tx_req | output | 1 | Attempt request to the line transmitter |
| tx_len | output | 5 | Frame byte count including header |
| tx_byte_idx | input | 4 | Frame byte index requested by the transmitter |
| tx_byte | output | 8 | Frame byte, one cycle after index |
| tx_done | input | 1 | Attempt finished, outcome valid |
| tx_result | input | 2 | Attempt outcome: 0 ack, 1 nack, 2 low-drive, 3 arbitration lost |
| irq_ready | output | 1 | Success status / interrupt |
| irq_arb_lost | output | 1 | Arbitration-lost status / interrupt |
| irq_retry_timeout | output | 1 | Retry-limit-exhausted status / interrupt |

## Verification
Each result has a known due cycle. A control write raises tx_req after the clock edge that takes the write. A tx_done pulse updates the counters, the status bits and the interrupts at the edge that samples it. A register read returns its value one edge after the address is applied. After a failure the request stays low for exactly GAP cycles. The bench drives inputs and samples outputs on the falling edge, so each check lands half a cycle after the edge that makes its result due. The bench also counts the low-request cycles between attempts and compares that count with GAP. The expected attempt count, counter values and ending interrupt are worked out from the retry limit and the outcome sequence of each table vector.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [1:0] {
    OUT_ACK    = 2'd0,
    OUT_NACK   = 2'd1,
    OUT_LOWDRV = 2'd2,
    OUT_ARB    = 2'd3
  } outcome_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SEND = 2'd1,
    S_GAP  = 2'd2
  } seq_state_t;

  localparam int STAT_READY   = 0;
  localparam int STAT_ARB     = 1;
  localparam int STAT_TIMEOUT = 2;
  localparam int STAT_W       = 3;
endpackage

// File: rtl/txr_frame_mem.sv
module txr_frame_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [IW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [IW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/txr_fail_cnt.sv
module txr_fail_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc && q != MAXV) q <= q + 1'b1;
  end

  // R9: a start clears the count on the following cycle
  a_r9_clear: assert property (@(posedge clk) disable iff (rst) clr |=> q == '0);
  // R4: a count only holds or steps up by one
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (q == $past(q) || q == $past(q) + 1'b1));
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int LIM_W = 3,
  parameter int GAP   = 8,
  localparam int GW   = (GAP > 1) ? $clog2(GAP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             done_i,
  input  outcome_t         result_i,
  output logic             busy_o,
  output logic             req_o,
  output logic             clr_cnt_o,
  output logic             inc_nack_o,
  output logic             inc_low_o,
  output logic             ev_ready_o,
  output logic             ev_arb_o,
  output logic             ev_timeout_o
);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP - 1);

  seq_state_t       state_q;
  logic [LIM_W-1:0] lim_q, used_q;
  logic [GW-1:0]    gap_q;
  logic             accept, fail, last;

  assign accept       = (state_q == S_SEND) && done_i;
  assign fail         = accept && (result_i == OUT_NACK || result_i == OUT_LOWDRV);
  assign last         = (used_q == lim_q);
  assign clr_cnt_o    = start_i && (state_q == S_IDLE);
  assign inc_nack_o   = accept && (result_i == OUT_NACK);
  assign inc_low_o    = accept && (result_i == OUT_LOWDRV);
  assign ev_ready_o   = accept && (result_i == OUT_ACK);
  assign ev_arb_o     = accept && (result_i == OUT_ARB);
  assign ev_timeout_o = fail && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      busy_o  <= 1'b0;
      req_o   <= 1'b0;
      lim_q   <= '0;
      used_q  <= '0;
      gap_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_SEND;
          busy_o  <= 1'b1;
          req_o   <= 1'b1;
          used_q  <= '0;
          lim_q   <= limit_i;
        end
        S_SEND: if (accept) begin
          req_o <= 1'b0;
          if (fail && !last) begin
            state_q <= S_GAP;
            gap_q   <= '0;
            used_q  <= used_q + 1'b1;
          end else begin
            state_q <= S_IDLE;
            busy_o  <= 1'b0;
          end
        end
        S_GAP: begin
          if (gap_q == GAP_LAST) begin
            state_q <= S_SEND;
            req_o   <= 1'b1;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2: a request is only raised inside an active transfer
  a_r2_req_busy: assert property (@(posedge clk) disable iff (rst) req_o |-> busy_o);
  // R6: the number of retries taken never exceeds the latched limit
  a_r6_used_bound: assert property (@(posedge clk) disable iff (rst) busy_o |-> used_q <= lim_q);
  // R5: the request stays low during the gap
  a_r5_gap_quiet: assert property (@(posedge clk) disable iff (rst) (state_q == S_GAP) |-> !req_o);
  // R7: arbitration loss returns to idle with no retry
  a_r7_arb_stop: assert property (@(posedge clk) disable iff (rst)
    (accept && result_i == OUT_ARB) |=> (state_q == S_IDLE && !req_o));
  // R3: every ending event leaves the block idle
  a_r3_end_idle: assert property (@(posedge clk) disable iff (rst)
    (ev_ready_o || ev_timeout_o) |=> !busy_o);
  // R10: a start while active leaves the latched limit untouched
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (start_i && state_q != S_IDLE) |=> lim_q == $past(lim_q));
endmodule

// File: rtl/frame_tx_retry.sv
module frame_tx_retry
  import txr_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DW      = 8,
  parameter int LIM_W   = 3,
  parameter int LIM_LSB = 4,
  parameter int GAP     = 8,
  localparam int IW     = $clog2(DEPTH),
  localparam int AW     = IW + 1,
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int CNT_W  = DW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tx_req,
  output logic [LEN_W-1:0] tx_len,
  input  logic [IW-1:0] tx_byte_idx,
  output logic [DW-1:0] tx_byte,
  input  logic          tx_done,
  input  logic [1:0]    tx_result,
  output logic          irq_ready,
  output logic          irq_arb_lost,
  output logic          irq_retry_timeout
);
  localparam logic [AW-1:0] OFF_LEN   = AW'(DEPTH);
  localparam logic [AW-1:0] OFF_RETRY = AW'(DEPTH + 1);
  localparam logic [AW-1:0] OFF_CTRL  = AW'(DEPTH + 2);
  localparam logic [AW-1:0] OFF_CNT   = AW'(DEPTH + 3);
  localparam logic [AW-1:0] OFF_STAT  = AW'(DEPTH + 4);

  logic             is_mem, start, stat_wr;
  logic [LEN_W-1:0] len_q;
  logic [LIM_W-1:0] retry_q;
  logic [STAT_W-1:0] stat_q, stat_set;
  logic [DW-1:0]    mem_rdata, reg_val, reg_val_q;
  logic             rd_mem_q;
  logic [CNT_W-1:0] nack_cnt, low_cnt;
  logic busy, clr_cnt, inc_nack, inc_low, ev_ready, ev_arb, ev_timeout;

  assign is_mem  = !reg_addr[AW-1];
  assign start   = reg_wr && (reg_addr == OFF_CTRL) && reg_wdata[0];
  assign stat_wr = reg_wr && (reg_addr == OFF_STAT);

  txr_frame_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk     (clk),
    .a_we    (reg_wr && is_mem),
    .a_addr  (reg_addr[IW-1:0]),
    .a_wdata (reg_wdata),
    .a_rdata (mem_rdata),
    .b_addr  (tx_byte_idx),
    .b_rdata (tx_byte)
  );

  txr_seq #(.LIM_W(LIM_W), .GAP(GAP)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .limit_i      (retry_q),
    .done_i       (tx_done),
    .result_i     (outcome_t'(tx_result)),
    .busy_o       (busy),
    .req_o        (tx_req),
    .clr_cnt_o    (clr_cnt),
    .inc_nack_o   (inc_nack),
    .inc_low_o    (inc_low),
    .ev_ready_o   (ev_ready),
    .ev_arb_o     (ev_arb),
    .ev_timeout_o (ev_timeout)
  );

  txr_fail_cnt #(.W(CNT_W)) u_nack_cnt (
    .clk (clk), .rst (rst), .clr (clr_cnt), .inc (inc_nack), .q (nack_cnt)
  );

  txr_fail_cnt #(.W(CNT_W)) u_low_cnt (
    .clk (clk), .rst (rst), .clr (clr_cnt), .inc (inc_low), .q (low_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '0;
      retry_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFF_LEN)   len_q   <= reg_wdata[LEN_W-1:0];
      if (reg_addr == OFF_RETRY) retry_q <= reg_wdata[LIM_LSB +: LIM_W];
    end
  end

  assign stat_set[STAT_READY]   = ev_ready;
  assign stat_set[STAT_ARB]     = ev_arb;
  assign stat_set[STAT_TIMEOUT] = ev_timeout;

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else if (stat_set[i]) stat_q[i] <= 1'b1;
      else if (stat_wr && reg_wdata[i]) stat_q[i] <= 1'b0;
    end
    // R8: a written 1 with no new event clears the bit
    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
      (stat_wr && reg_wdata[i] && !stat_set[i]) |=> !stat_q[i]);
  end

  always_comb begin
    reg_val = '0;
    case (reg_addr)
      OFF_LEN:   reg_val = DW'(len_q);
      OFF_RETRY: reg_val = DW'(retry_q) << LIM_LSB;
      OFF_CTRL:  reg_val = DW'(busy);
      OFF_CNT:   reg_val = {low_cnt, nack_cnt};
      OFF_STAT:  reg_val = DW'(stat_q);
      default:   reg_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_val_q <= '0;
      rd_mem_q  <= 1'b0;
    end else begin
      reg_val_q <= reg_val;
      rd_mem_q  <= is_mem;
    end
  end

  assign reg_rdata         = rd_mem_q ? mem_rdata : reg_val_q;
  assign tx_len            = len_q;
  assign irq_ready         = stat_q[STAT_READY];
  assign irq_arb_lost      = stat_q[STAT_ARB];
  assign irq_retry_timeout = stat_q[STAT_TIMEOUT];

  // R3: at most one status bit becomes set in any cycle
  a_r3_one_irq: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stat_q & ~$past(stat_q)));
  // R7: an arbitration-lost ending leaves the counters as they were
  a_r7_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_result == 2'd3 && busy) |=> $stable({low_cnt, nack_cnt}));
endmodule

// File: tb/frame_tx_retry_tb.sv
module frame_tx_retry_tb;
  localparam int GAP = 8;
  localparam logic [4:0] A_LEN = 5'h10, A_RETRY = 5'h11, A_CTRL = 5'h12,
                         A_CNT = 5'h13, A_STAT = 5'h14;
  // vector: {limit[2:0], nfail[3:0], kind (0 nack / 1 low-drive), final (0 ack / 1 arb)}
  localparam int NV = 7;
  localparam logic [8:0] VEC [NV] = '{
    {3'd3, 4'd0, 1'b0, 1'b0},
    {3'd3, 4'd2, 1'b0, 1'b0},
    {3'd2, 4'd3, 1'b1, 1'b0},
    {3'd0, 4'd1, 1'b0, 1'b0},
    {3'd1, 4'd1, 1'b1, 1'b1},
    {3'd4, 4'd0, 1'b0, 1'b1},
    {3'd7, 4'd8, 1'b0, 1'b0}
  };

  logic clk = 0, rst = 1;
  logic reg_wr = 0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic tx_req, tx_done = 0;
  logic [4:0] tx_len;
  logic [3:0] tx_byte_idx = '0;
  logic [7:0] tx_byte;
  logic [1:0] tx_result = '0;
  logic irq_ready, irq_arb_lost, irq_retry_timeout;
  int checks = 0, failures = 0, cycles = 0;

  always #5 clk = ~clk;

  frame_tx_retry #(.GAP(GAP)) u_dut (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .tx_req, .tx_len,
    .tx_byte_idx, .tx_byte, .tx_done, .tx_result, .irq_ready, .irq_arb_lost,
    .irq_retry_timeout
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic respond(logic [1:0] res);
    while (!tx_req) @(negedge clk);
    repeat (2) @(negedge clk);
    tx_done = 1; tx_result = res;
    @(negedge clk);
    tx_done = 0;
  endtask

  task automatic measure_gap();
    int gap = 0;
    while (!tx_req) begin gap++; @(negedge clk); end
    check("R5 gap", gap, GAP);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 req", tx_req, 0);
    check("R1 irq", {irq_retry_timeout, irq_arb_lost, irq_ready}, 0);
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_CNT, d);  check("R1 cnt", d, 0);
    rd(A_STAT, d); check("R1 stat", d, 0);

    // R11 / R12 frame storage
    for (int i = 0; i < 4; i++) wr(5'(i), 8'hA0 + 8'(i));
    wr(A_LEN, 8'd4);
    rd(5'd2, d); check("R12 data read", d, 8'hA2);
    rd(A_LEN, d); check("R12 len read", d, 4);
    check("R11 tx_len", tx_len, 4);
    tx_byte_idx = 4'd3; @(negedge clk);
    check("R11 byte port", tx_byte, 8'hA3);
    wr(A_RETRY, 8'h50); rd(A_RETRY, d); check("R6 retry field", d, 8'h50);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0] lim; logic [3:0] nf; logic kind, fin;
      int att, fails; logic [2:0] exp_irq; logic [1:0] fres;
      {lim, nf, kind, fin} = VEC[v];
      if (nf > lim) begin att = lim + 1; fails = lim + 1; exp_irq = 3'b100; end
      else begin att = nf + 1; fails = nf; exp_irq = fin ? 3'b010 : 3'b001; end
      fres = kind ? 2'd2 : 2'd1;
      wr(A_RETRY, {1'b0, lim, 4'b0});
      wr(A_CTRL, 8'h01);
      check("R2 req", tx_req, 1);
      rd(A_CTRL, d); check("R2 ctrl busy", d, 1);
      rd(A_CNT, d); check("R9 cnt cleared", d, 0);
      for (int a = 0; a < att; a++) begin
        respond((a < nf) ? fres : (fin ? 2'd3 : 2'd0));
        if (a < att - 1) measure_gap();
      end
      repeat (2) @(negedge clk);
      check("R3/R6/R7 req low", tx_req, 0);
      rd(A_CTRL, d); check("R3 ctrl idle", d, 0);
      rd(A_CNT, d);
      check("R4 counters", d, kind ? (fails << 4) : fails);
      check("R3/R6/R7 irq", {irq_retry_timeout, irq_arb_lost, irq_ready}, exp_irq);
      wr(A_STAT, 8'h00);
      check("R8 zero write keeps", {irq_retry_timeout, irq_arb_lost, irq_ready}, exp_irq);
      wr(A_STAT, 8'h07);
      check("R8 w1c", {irq_retry_timeout, irq_arb_lost, irq_ready}, 0);
    end

    // R10: start while active is ignored
    wr(A_RETRY, 8'h10);
    wr(A_CTRL, 8'h01);
    respond(2'd1);
    measure_gap();
    wr(A_CTRL, 8'h01);
    rd(A_CNT, d); check("R10 cnt kept", d, 1);
    respond(2'd0);
    @(negedge clk);
    check("R10 ended", tx_req, 0);
    check("R10 irq", {irq_retry_timeout, irq_arb_lost, irq_ready}, 3'b001);
    rd(A_CNT, d); check("R10 cnt final", d, 1);
    wr(A_STAT, 8'h01);
    wr(A_CTRL, 8'h00);
    repeat (GAP + 4) @(negedge clk);
    check("R10 no extra attempt", tx_req, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule